// File: doc/BRIEF.md
# Linear Instruction Prefetch Unit

This block feeds a processor's decode stage with instruction words. After reset it begins at a boot address. It issues word-aligned read requests to instruction memory over a request/grant/response handshake and steps forward one word per granted request. The words that come back are stored in a small in-order fetch FIFO. Each stored word carries the address it was fetched from and the memory error flag that came with it. A consumer drains the FIFO through a valid/ready pop interface. Fetching pauses once the stored words plus the live requests still in flight would fill the FIFO, and it resumes as space frees up. The memory side is read-only and has no write signals.

When control flow changes (a branch, a jump or an exception), the core pulses a flush with a new target address. The FIFO is emptied. Every request already granted is marked for discard, and its response is dropped on arrival. Fetching restarts at the word that holds the target. If the target is halfword aligned, the first word fetched from the new path is tagged with that offset.

Request issue is controlled by a three-state machine:
- `S_IDLE`: no request is driven. It moves to `S_REQ` when the next-cycle counts leave room.
- `S_REQ`: a request is driven at the current fetch address.
  - On a grant it stays in `S_REQ` if room remains, and otherwise drops to `S_IDLE`.
  - A flush in the same cycle as a grant takes the same room test, now against the new path.
  - A flush with no grant moves it to `S_STALE`.
- `S_STALE`: the old request, which the handshake does not allow to be withdrawn, stays on the bus at its old address. When it is granted it is counted as a discard, and the machine moves to `S_REQ` or `S_IDLE` on the room test.

Top module: `pf_linear_fetch`

## Requirements
- R1: Once the request output is high without a grant, it stays high in the next cycle with the same address, even if a flush arrives in between.
- R2: Every request address has its two low bits at zero. The first request after reset is at BOOT_ADDR (default 0x80).
- R3: Requests on one path go to consecutive words. Each grant advances the address by 4.
- R4: A new-path request is driven only while the FIFO fill count plus the live granted requests not yet answered is below DEPTH. With the consumer stalled, the FIFO reaches DEPTH entries and requesting stops.
- R5: Responses from the live path enter the FIFO in order. out_valid_o is high exactly when the FIFO holds a word. Each entry shows the read data, the error flag and the fetch address, and appears one cycle after its response.
- R6: A flush empties the FIFO by the next cycle. It ignores a pop in the same cycle. The next new request is at the target address with its two low bits cleared.
- R7: A response to a request granted before or in the flush cycle is discarded, and so is a response to a request held over the flush. A response that arrives in the flush cycle itself is also discarded.
- R8: After a flush to a halfword-aligned target, the first entry of the new path has bit 1 of out_pc_o set. Later entries have it clear.
- R9: The number of granted requests still awaiting a response, live or discarded, never exceeds MAX_OUT (default 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | One-cycle pulse: drop in-flight and buffered words, restart at flush_pc_i |
| flush_pc_i | input | 32 | New target address; bit 0 is ignored |
| fetch_req_o | output | 1 | Read request valid |
| fetch_addr_o | output | 32 | Word-aligned read address |
| fetch_gnt_i | input | 1 | Memory accepted the request this cycle |
| fetch_rvalid_i | input | 1 | Response valid, one cycle per granted request |
| fetch_rdata_i | input | 32 | Response data |
| fetch_err_i | input | 1 | Response access error |
| out_valid_o | output | 1 | FIFO head holds a word |
| out_ready_i | input | 1 | Consumer takes the head word |
| out_data_o | output | 32 | Head word data |
| out_pc_o | output | 32 | Head word address; bit 1 marks a halfword target |
| out_err_o | output | 1 | Head word error flag |

## Verification
A wrong count of live or discarded requests shows up at the ports within one response. If too few requests are marked for discard, an old-path word reaches out_valid_o in the cycle after its response. If too many are marked, a new-path word never appears, and the per-cycle comparison against the reference queue catches this at once. A wrong fetch address is seen in the same cycle the request is driven. A wrong room decision appears as a request beyond the FIFO budget, or as a FIFO that never fills while the consumer is stalled.

// File: rtl/pf_pkg.sv
package pf_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_REQ   = 2'd1,
        S_STALE = 2'd2
    } req_state_e;

    typedef struct packed {
        logic [31:0] data;
        logic [31:2] pc_w;
        logic        hoff;
        logic        err;
    } fetch_entry_t;

endpackage

// File: rtl/pf_req_fsm.sv
module pf_req_fsm
    import pf_pkg::*;
#(
    parameter logic [31:0] BOOT_ADDR = 32'h0000_0080
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        flush_i,
    input  logic [31:2] flush_pcw_i,
    input  logic        gnt_i,
    input  logic        room_nxt_i,
    output logic        req_o,
    output logic [31:0] addr_o,
    output logic        gnt_live_o,
    output logic        gnt_drop_o
);

    req_state_e  state_q, state_d;
    logic [31:2] pc_q;
    logic [31:2] stale_q;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= S_IDLE;
        else         state_q <= state_d;
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                state_d = room_nxt_i ? S_REQ : S_IDLE;
            end
            S_REQ: begin
                if (flush_i && !gnt_i)      state_d = S_STALE;
                else if (gnt_i || flush_i)  state_d = room_nxt_i ? S_REQ : S_IDLE;
                else                        state_d = S_REQ;
            end
            S_STALE: begin
                if (gnt_i) state_d = room_nxt_i ? S_REQ : S_IDLE;
                else       state_d = S_STALE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_o      = (state_q != S_IDLE);
        addr_o     = (state_q == S_STALE) ? {stale_q, 2'b00} : {pc_q, 2'b00};
        gnt_live_o = gnt_i && (state_q == S_REQ);
        gnt_drop_o = gnt_i && (state_q == S_STALE);
    end

    // fetch address and held address
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pc_q    <= BOOT_ADDR[31:2];
            stale_q <= BOOT_ADDR[31:2];
        end else begin
            if (flush_i)         pc_q <= flush_pcw_i;
            else if (gnt_live_o) pc_q <= pc_q + 30'd1;
            if (state_q == S_REQ && flush_i && !gnt_i) stale_q <= pc_q;
        end
    end

    p_req_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o && !gnt_i) |=> (req_o && addr_o == $past(addr_o)));

    p_seq_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt_live_o && !flush_i) |=> (!req_o || addr_o == $past(addr_o) + 32'd4));

    p_flush_target_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flush_i && !(req_o && !gnt_i)) |=> (!req_o || addr_o[31:2] == $past(flush_pcw_i)));

endmodule

// File: rtl/pf_track.sv
module pf_track #(
    parameter int          DEPTH     = 3,
    parameter int          MAX_OUT   = 4,
    parameter logic [31:0] BOOT_ADDR = 32'h0000_0080,
    localparam int         FW        = $clog2(DEPTH + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          flush_i,
    input  logic [31:1]   flush_pch_i,
    input  logic          gnt_live_i,
    input  logic          gnt_drop_i,
    input  logic          rvalid_i,
    input  logic [FW-1:0] fifo_cnt_nxt_i,
    output logic          push_o,
    output logic          drop_pend_o,
    output logic [31:2]   resp_pcw_o,
    output logic          resp_hoff_o,
    output logic          room_nxt_o
);

    localparam int OW = $clog2(MAX_OUT + 1);

    logic [OW-1:0] live_q, drop_q;
    logic [OW-1:0] live_a, drop_a, live_d, drop_d;
    logic          drop_resp, live_resp;
    logic [31:2]   rpc_q;
    logic          hoff_q;

    always_comb begin
        drop_resp = rvalid_i && (drop_q != '0);
        live_resp = rvalid_i && !drop_resp;
        push_o    = live_resp && !flush_i;
        live_a    = live_q - OW'(live_resp) + OW'(gnt_live_i);
        drop_a    = drop_q - OW'(drop_resp) + OW'(gnt_drop_i);
        live_d    = flush_i ? '0 : live_a;
        drop_d    = flush_i ? drop_a + live_a : drop_a;
        room_nxt_o = ((int'(fifo_cnt_nxt_i) + int'(live_d)) < DEPTH) &&
                     ((int'(live_d) + int'(drop_d)) < MAX_OUT);
    end

    assign drop_pend_o = (drop_q != '0);
    assign resp_pcw_o  = rpc_q;
    assign resp_hoff_o = hoff_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            live_q <= '0;
            drop_q <= '0;
            rpc_q  <= BOOT_ADDR[31:2];
            hoff_q <= BOOT_ADDR[1];
        end else begin
            live_q <= live_d;
            drop_q <= drop_d;
            if (flush_i) begin
                rpc_q  <= flush_pch_i[31:2];
                hoff_q <= flush_pch_i[1];
            end else if (push_o) begin
                rpc_q  <= rpc_q + 30'd1;
                hoff_q <= 1'b0;
            end
        end
    end

    p_out_limit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(live_q) + int'(drop_q)) <= MAX_OUT);

endmodule

// File: rtl/pf_fifo.sv
module pf_fifo
    import pf_pkg::*;
#(
    parameter int  DEPTH = 3,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         flush_i,
    input  logic         push_i,
    input  fetch_entry_t entry_i,
    input  logic         pop_i,
    output logic         valid_o,
    output fetch_entry_t entry_o,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] cnt_nxt_o
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    fetch_entry_t  mem_q [DEPTH];
    logic [PW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;
    logic          do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        do_pop    = pop_i && (cnt_q != '0) && !flush_i;
        cnt_nxt_o = flush_i ? '0 : cnt_q + CW'(push_i) - CW'(do_pop);
        valid_o   = (cnt_q != '0);
        entry_o   = mem_q[rd_q];
        cnt_o     = cnt_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt_o;
            if (flush_i) begin
                rd_q <= '0;
                wr_q <= '0;
            end else begin
                if (push_i) wr_q <= bump(wr_q);
                if (do_pop) rd_q <= bump(rd_q);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (push_i) mem_q[wr_q] <= entry_i;
    end

    p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        push_i |-> (cnt_q < CW'(DEPTH)));

endmodule

// File: rtl/pf_linear_fetch.sv
module pf_linear_fetch
    import pf_pkg::*;
#(
    parameter int          DEPTH     = 3,
    parameter int          MAX_OUT   = 4,
    parameter logic [31:0] BOOT_ADDR = 32'h0000_0080
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        flush_i,
    input  logic [31:0] flush_pc_i,
    output logic        fetch_req_o,
    output logic [31:0] fetch_addr_o,
    input  logic        fetch_gnt_i,
    input  logic        fetch_rvalid_i,
    input  logic [31:0] fetch_rdata_i,
    input  logic        fetch_err_i,
    output logic        out_valid_o,
    input  logic        out_ready_i,
    output logic [31:0] out_data_o,
    output logic [31:0] out_pc_o,
    output logic        out_err_o
);

    localparam int FW = $clog2(DEPTH + 1);

    logic          gnt_live, gnt_drop, room_nxt, push, drop_pend, resp_hoff;
    logic [31:2]   resp_pcw;
    logic [FW-1:0] fifo_cnt, fifo_cnt_nxt;
    fetch_entry_t  entry_in, entry_out;

    pf_req_fsm #(.BOOT_ADDR(BOOT_ADDR)) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .flush_i     (flush_i),
        .flush_pcw_i (flush_pc_i[31:2]),
        .gnt_i       (fetch_gnt_i),
        .room_nxt_i  (room_nxt),
        .req_o       (fetch_req_o),
        .addr_o      (fetch_addr_o),
        .gnt_live_o  (gnt_live),
        .gnt_drop_o  (gnt_drop)
    );

    pf_track #(.DEPTH(DEPTH), .MAX_OUT(MAX_OUT), .BOOT_ADDR(BOOT_ADDR)) u_track (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .flush_i        (flush_i),
        .flush_pch_i    (flush_pc_i[31:1]),
        .gnt_live_i     (gnt_live),
        .gnt_drop_i     (gnt_drop),
        .rvalid_i       (fetch_rvalid_i),
        .fifo_cnt_nxt_i (fifo_cnt_nxt),
        .push_o         (push),
        .drop_pend_o    (drop_pend),
        .resp_pcw_o     (resp_pcw),
        .resp_hoff_o    (resp_hoff),
        .room_nxt_o     (room_nxt)
    );

    always_comb begin
        entry_in.data = fetch_rdata_i;
        entry_in.pc_w = resp_pcw;
        entry_in.hoff = resp_hoff;
        entry_in.err  = fetch_err_i;
    end

    pf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .flush_i   (flush_i),
        .push_i    (push),
        .entry_i   (entry_in),
        .pop_i     (out_ready_i),
        .valid_o   (out_valid_o),
        .entry_o   (entry_out),
        .cnt_o     (fifo_cnt),
        .cnt_nxt_o (fifo_cnt_nxt)
    );

    assign out_data_o = entry_out.data;
    assign out_pc_o   = {entry_out.pc_w, entry_out.hoff, 1'b0};
    assign out_err_o  = entry_out.err;

    p_addr_align_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fetch_req_o |-> (fetch_addr_o[1:0] == 2'b00));

    p_drop_stale_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fetch_rvalid_i && drop_pend) |=> (fifo_cnt <= $past(fifo_cnt)));

    p_flush_empty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> !out_valid_o);

endmodule

// File: tb/pf_linear_fetch_bench.sv
module pf_linear_fetch_bench;

    localparam int          DEPTH   = 3;
    localparam int          MAX_OUT = 4;
    localparam logic [31:0] BOOT    = 32'h0000_0080;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [31:0] flush_pc = '0;
    logic        req;
    logic [31:0] addr;
    logic        gnt = 1'b0;
    logic        rvalid = 1'b0;
    logic [31:0] rdata = '0;
    logic        rerr = 1'b0;
    logic        ovalid;
    logic        ready = 1'b0;
    logic [31:0] odata, opc;
    logic        oerr;

    always #5 clk = ~clk;

    pf_linear_fetch #(.DEPTH(DEPTH), .MAX_OUT(MAX_OUT), .BOOT_ADDR(BOOT)) u_pf_linear_fetch (
        .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .flush_pc_i(flush_pc),
        .fetch_req_o(req), .fetch_addr_o(addr), .fetch_gnt_i(gnt),
        .fetch_rvalid_i(rvalid), .fetch_rdata_i(rdata), .fetch_err_i(rerr),
        .out_valid_o(ovalid), .out_ready_i(ready), .out_data_o(odata),
        .out_pc_o(opc), .out_err_o(oerr)
    );

    typedef struct { logic [31:0] d; logic [31:0] pc; logic e; } exp_t;
    typedef struct { logic [31:0] a; int ep; int due; } ost_t;

    exp_t expq[$];
    ost_t ostq[$];

    int n_chk = 0, n_err = 0, cyc = 0;
    int gnt_pct = 100, rdy_pct = 100;
    int epoch = 0;
    logic [31:0] next_addr = BOOT;
    bit first_new = 1'b1, tgt_odd = 1'b0, stale_pend = 1'b0;
    bit prev_wait = 1'b0;
    logic [31:0] prev_addr = '0;
    logic [15:0] lfsr = 16'hACE1;
    bit flush_req = 1'b0;
    logic [31:0] flush_tgt = '0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, expv);
        end
    endtask

    function automatic logic [31:0] mem_data(input logic [31:0] a);
        return a ^ 32'h5A5A_0000 ^ {a[15:0], 16'h0000};
    endfunction

    function automatic int live_count();
        int n = 0;
        foreach (ostq[i]) if (ostq[i].ep == epoch) n++;
        return n;
    endfunction

    always @(negedge clk) begin
        cyc++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (!rst_n) begin
            if (cyc == 3) begin
                chk(req == 1'b0, "R2", "req in reset", 32'(req), 0);
                chk(ovalid == 1'b0, "R5", "valid in reset", 32'(ovalid), 0);
            end
        end else begin
            // compare outputs against the reference model
            chk(ovalid == (expq.size() > 0), "R5", "out_valid", 32'(ovalid), 32'(expq.size() > 0));
            if (ovalid && expq.size() > 0) begin
                chk(odata == expq[0].d, "R5", "out_data", odata, expq[0].d);
                chk(opc == expq[0].pc, "R8", "out_pc", opc, expq[0].pc);
                chk(oerr == expq[0].e, "R5", "out_err", 32'(oerr), 32'(expq[0].e));
            end
            if (prev_wait) begin
                chk(req == 1'b1, "R1", "req held", 32'(req), 1);
                chk(addr == prev_addr, "R1", "addr held", addr, prev_addr);
            end
            if (req) chk(addr[1:0] == 2'b00, "R2", "addr align", addr, addr & ~32'h3);
            if (req && !stale_pend) begin
                chk(addr == next_addr, "R3", "fetch addr", addr, next_addr);
                chk(live_count() + expq.size() < DEPTH, "R4", "room budget",
                    32'(live_count() + expq.size()), 32'(DEPTH - 1));
            end
            chk(ostq.size() <= MAX_OUT, "R9", "outstanding", 32'(ostq.size()), MAX_OUT);

            // drive memory and consumer for this cycle
            gnt    = req && ((int'(lfsr[15:8]) % 100) < gnt_pct);
            ready  = (int'(lfsr[7:0]) % 100) < rdy_pct;
            flush  = flush_req;
            flush_pc = flush_tgt;
            rvalid = 1'b0;
            if (ostq.size() > 0 && ostq[0].due <= cyc) begin
                rvalid = 1'b1;
                rdata  = mem_data(ostq[0].a);
                rerr   = (ostq[0].a[5:2] == 4'hB);
            end else begin
                rdata = '0;
                rerr  = 1'b0;
            end

            // model the coming edge
            if (ready && expq.size() > 0 && !flush) void'(expq.pop_front());
            if (rvalid) begin
                ost_t o;
                o = ostq.pop_front();
                if (o.ep == epoch && !flush) begin
                    exp_t e;
                    e.d  = rdata;
                    e.pc = o.a | ((first_new && tgt_odd) ? 32'h2 : 32'h0);
                    e.e  = rerr;
                    expq.push_back(e);
                    first_new = 1'b0;
                end
            end
            if (req && gnt) begin
                ost_t o;
                o.a   = addr;
                o.ep  = stale_pend ? -1 : epoch;
                o.due = cyc + 1 + (int'(lfsr[3:2]) % 3);
                ostq.push_back(o);
                if (stale_pend) stale_pend = 1'b0;
                else next_addr = next_addr + 32'd4;
            end
            if (flush) begin
                if (req && !gnt) stale_pend = 1'b1;
                epoch++;
                expq.delete();
                next_addr = flush_pc & ~32'h3;
                first_new = 1'b1;
                tgt_odd   = flush_pc[1];
            end
            prev_wait = req && !gnt;
            prev_addr = addr;
        end
    end

    task automatic do_flush(input logic [31:0] t);
        @(posedge clk);
        flush_req = 1'b1;
        flush_tgt = t;
        @(negedge clk);
        #1;
        flush_req = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        rdy_pct = 0;
        gnt_pct = 100;
        wait_cyc(5);
        rst_n = 1'b1;
        // R4: consumer stalled, FIFO fills and requests stop
        wait_cyc(25);
        chk(expq.size() == DEPTH, "R4", "fill level", 32'(expq.size()), DEPTH);
        chk(req == 1'b0, "R4", "req stops when full", 32'(req), 0);
        chk(opc == BOOT, "R2", "first word from boot", opc, BOOT);
        // drain and stream
        rdy_pct = 100;
        gnt_pct = 60;
        wait_cyc(100);
        // R6/R7: flush while streaming, back-to-back flushes
        do_flush(32'h0000_0100);
        wait_cyc(3);
        do_flush(32'h0000_0200);
        do_flush(32'h0000_0240);
        wait_cyc(30);
        // R1/R7: request held across a flush
        gnt_pct = 0;
        wait_cyc(4);
        do_flush(32'h0000_0300);
        wait_cyc(3);
        gnt_pct = 100;
        wait_cyc(20);
        // R8: halfword target
        rdy_pct = 0;
        do_flush(32'h0000_0402);
        wait_cyc(12);
        chk(ovalid == 1'b1, "R8", "valid after odd flush", 32'(ovalid), 1);
        chk(opc == 32'h0000_0402, "R8", "halfword pc", opc, 32'h0000_0402);
        rdy_pct = 100;
        wait_cyc(10);
        // mixed random traffic with periodic flushes
        rdy_pct = 70;
        gnt_pct = 70;
        for (int k = 0; k < 60; k++) begin
            wait_cyc(20 + (k % 7));
            do_flush({20'h0, lfsr[11:1], 1'b0});
        end
        rdy_pct = 100;
        gnt_pct = 100;
        wait_cyc(40);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule